// File: doc/BRIEF.md
# Low-Power Real-Time Clock with Staged Bring-Up

This block is a real-time clock for an always-on, low-power domain. A 32-bit bus register interface on a fast clock reaches a small set of registers: a seconds count, a sub-second tick count, an alarm compare value, a control word, a status word and a supply-integrity key word. Counting, alarm matching and the validity state machine run on a slow, asynchronous counting clock. Every bus write is captured on the fast side and handed across to the slow side through a toggle synchronizer, so it lands a few slow ticks after the bus cycle.

The counter does not run straight out of reset. Software stores a fixed key in the integrity register, clears status, and requests the exit from the init state. It waits for the matching status bit, then requests the exit from the non-valid state together with low-power enable, and waits for the second status bit. From then on the sub-second counter advances on every slow tick. The seconds counter advances each time the sub-second counter wraps. An alarm flag raises an interrupt line and a wakeup line, each under its own enable. If the key word is disturbed, the clock drops back to the non-valid state and stops.

Top module: `rtc_lowpower`

## Requirements
- R1: After reset every register reads 0, and `alarmIrq` and `wakeup` are low.
- R2: Byte offsets are seconds 0x00, sub-second 0x04, alarm 0x08, control 0x10, status 0x14 and key 0x18. The key register keeps all 32 bits. The control register keeps only bits 3, 4, 7, 11, 14 and 15 and reads the rest as 0. The sub-second register cannot be written. Any other offset reads 0.
- R3: A write to seconds or alarm takes effect only if control bit 11 (write permit) is set when the write reaches the slow domain. Otherwise it has no effect.
- R4: A bus write is applied in the slow domain no later than the third slow-clock rising edge after the bus edge that accepts it.
- R5: Status bit 15 sets, and the state leaves init, only when the key register holds 0x41736166 and control bit 15 is set. It sets no earlier than two slow ticks after the control write.
- R6: From the non-valid state, with the key present and control bits 15 and 14 set, status bit 14 sets and the state becomes valid.
- R7: In the valid state with control bit 3 set, the sub-second counter counts modulo TICKS_PER_SEC on each slow tick, and seconds rises by one at each wrap. In any other condition both counters hold their values. A seconds write clears the sub-second counter.
- R8: The seconds counter saturates at 0xFFFFFFFF and never rolls over.
- R9: In the valid state, status bit 3 (alarm flag) sets whenever seconds equals the alarm value. Writing 1 to status bits 3, 14 or 15 clears them, and a write of 0 to a bit leaves it unchanged.
- R10: `alarmIrq` is the alarm flag ANDed with control bit 7. `wakeup` is the alarm flag ANDed with control bit 4.
- R11: If the key register no longer holds 0x41736166 in the valid state, the state returns to non-valid, status bit 14 clears, and counting stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| slowClk | input | 1 | Slow asynchronous counting clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| wrEn | input | 1 | Register write strobe, one bus cycle |
| addr | input | ADDR_W | Byte offset for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data at `addr` |
| alarmIrq | output | 1 | Alarm interrupt |
| wakeup | output | 1 | Wakeup request |

## Verification
The slow-domain assertions assume that the write request and its data, held on the bus side, do not change while the toggle is passing through the synchronizer. In practice, two bus writes must be at least three slow ticks apart. The bench follows this by waiting five slow ticks after every write it wants applied, except in the latency check, which waits exactly three. The slow clock is an odd multiple of the bus clock with its edges offset, so reads land away from every slow edge and the counter values the bench samples are settled.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
  // byte offsets
  localparam int OFF_SECS   = 0;
  localparam int OFF_SUB    = 4;
  localparam int OFF_ALARM  = 8;
  localparam int OFF_CTRL   = 16;
  localparam int OFF_STAT   = 20;
  localparam int OFF_KEY    = 24;

  // control bit positions
  localparam int C_LPEN     = 3;
  localparam int C_WAKE     = 4;
  localparam int C_IRQEN    = 7;
  localparam int C_PERMIT   = 11;
  localparam int C_NVEXIT   = 14;
  localparam int C_INITEXIT = 15;

  // status bit positions
  localparam int S_ALARM    = 3;
  localparam int S_NVDONE   = 14;
  localparam int S_INITDONE = 15;

  localparam logic [31:0] CTRL_MASK = 32'h0000_C898;
  localparam logic [31:0] STAT_MASK = 32'h0000_C008;
  localparam logic [31:0] KEY_VALUE = 32'h4173_6166;

  typedef enum logic [2:0] {SEL_SECS, SEL_ALARM, SEL_CTRL, SEL_STAT, SEL_KEY} regSel_e;
  typedef enum logic [1:0] {LP_INIT, LP_NONVALID, LP_VALID} lpState_e;

  // write request handed from bus side to slow side
  typedef struct packed {
    logic        toggle;
    regSel_e     sel;
    logic [31:0] data;
  } wrReq_t;

  // slow-side register view for the read mux
  typedef struct packed {
    logic [31:0] secs;
    logic [31:0] sub;
    logic [31:0] alarm;
    logic [31:0] ctrl;
    logic [31:0] status;
    logic [31:0] key;
  } coreView_t;
endpackage

// File: rtl/rtc_bus_ctrl.sv
module rtc_bus_ctrl
  import rtc_lp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  coreView_t         view,
  output wrReq_t            req,
  output logic [31:0]       rdData
);
  logic    hit;
  regSel_e selD;

  // write decode: sub-second and unmapped offsets raise no request
  always_comb begin
    hit  = 1'b1;
    selD = SEL_SECS;
    if (addr == ADDR_W'(OFF_SECS))       selD = SEL_SECS;
    else if (addr == ADDR_W'(OFF_ALARM)) selD = SEL_ALARM;
    else if (addr == ADDR_W'(OFF_CTRL))  selD = SEL_CTRL;
    else if (addr == ADDR_W'(OFF_STAT))  selD = SEL_STAT;
    else if (addr == ADDR_W'(OFF_KEY))   selD = SEL_KEY;
    else                                 hit  = 1'b0;
  end

  // hold the request; flipping the toggle announces it to the slow side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      req <= '0;
    end else if (wrEn && hit) begin
      req.toggle <= ~req.toggle;
      req.sel    <= selD;
      req.data   <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(OFF_SECS))       rdData = view.secs;
    else if (addr == ADDR_W'(OFF_SUB))   rdData = view.sub;
    else if (addr == ADDR_W'(OFF_ALARM)) rdData = view.alarm;
    else if (addr == ADDR_W'(OFF_CTRL))  rdData = view.ctrl;
    else if (addr == ADDR_W'(OFF_STAT))  rdData = view.status;
    else if (addr == ADDR_W'(OFF_KEY))   rdData = view.key;
  end
endmodule

// File: rtl/rtc_lp_core.sv
module rtc_lp_core
  import rtc_lp_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic      slowClk,
  input  logic      rstN,
  input  wrReq_t    req,
  output coreView_t view,
  output logic      alarmIrq,
  output logic      wakeup
);
  localparam int SUB_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);

  logic [2:0]       togSync;
  logic             applyW;
  logic [31:0]      secsQ, secsD, alarmQ, alarmD, ctrlQ, ctrlD;
  logic [31:0]      statQ, statD, keyQ, keyD;
  logic [SUB_W-1:0] subQ, subD;
  lpState_e         stateQ, stateD;
  logic             keyOk, running, permit;

  // toggle synchronizer: a change seen at the last two stages is one write
  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) togSync <= '0;
    else       togSync <= {togSync[1:0], req.toggle};
  end
  assign applyW = togSync[2] ^ togSync[1];

  assign keyOk   = (keyQ == KEY_VALUE);
  assign running = (stateQ == LP_VALID) && ctrlQ[C_LPEN];
  assign permit  = ctrlQ[C_PERMIT];

  always_comb begin
    secsD  = secsQ;
    subD   = subQ;
    alarmD = alarmQ;
    ctrlD  = ctrlQ;
    statD  = statQ;
    keyD   = keyQ;
    stateD = stateQ;

    if (running) begin
      if (subQ == SUB_LAST) begin
        subD = '0;
        if (secsQ != '1) secsD = secsQ + 32'd1;
      end else begin
        subD = subQ + 1'b1;
      end
    end

    if (applyW) begin
      case (req.sel)
        SEL_SECS:  if (permit) begin secsD = req.data; subD = '0; end
        SEL_ALARM: if (permit) alarmD = req.data;
        SEL_CTRL:  ctrlD = req.data & CTRL_MASK;
        SEL_STAT:  statD = statQ & ~(req.data & STAT_MASK);
        SEL_KEY:   keyD  = req.data;
        default:   ;
      endcase
    end

    case (stateQ)
      LP_INIT:
        if (keyOk && ctrlQ[C_INITEXIT]) begin
          stateD = LP_NONVALID;
          statD[S_INITDONE] = 1'b1;
        end
      LP_NONVALID:
        if (keyOk && ctrlQ[C_INITEXIT] && ctrlQ[C_NVEXIT]) begin
          stateD = LP_VALID;
          statD[S_NVDONE] = 1'b1;
        end
      default:
        if (!keyOk) begin
          stateD = LP_NONVALID;
          statD[S_NVDONE] = 1'b0;
        end
    endcase

    if ((stateQ == LP_VALID) && (secsQ == alarmQ)) statD[S_ALARM] = 1'b1;
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      secsQ  <= '0;
      subQ   <= '0;
      alarmQ <= '0;
      ctrlQ  <= '0;
      statQ  <= '0;
      keyQ   <= '0;
      stateQ <= LP_INIT;
    end else begin
      secsQ  <= secsD;
      subQ   <= subD;
      alarmQ <= alarmD;
      ctrlQ  <= ctrlD;
      statQ  <= statD;
      keyQ   <= keyD;
      stateQ <= stateD;
    end
  end

  assign alarmIrq = statQ[S_ALARM] & ctrlQ[C_IRQEN];
  assign wakeup   = statQ[S_ALARM] & ctrlQ[C_WAKE];

  assign view.secs   = secsQ;
  assign view.sub    = 32'(subQ);
  assign view.alarm  = alarmQ;
  assign view.ctrl   = ctrlQ;
  assign view.status = statQ;
  assign view.key    = keyQ;

  // R8: once saturated, only a seconds write may move the counter
  a_r8_no_rollover: assert property (@(posedge slowClk) disable iff (!rstN)
    (secsQ == '1 && !(applyW && req.sel == SEL_SECS)) |=> secsQ == '1);

  // R7: counters frozen outside valid+enabled when no write lands
  a_r7_frozen: assert property (@(posedge slowClk) disable iff (!rstN)
    (!running && !applyW) |=> ($stable(secsQ) && $stable(subQ)));

  // R3: alarm write without permit has no effect
  a_r3_permit: assert property (@(posedge slowClk) disable iff (!rstN)
    (applyW && req.sel == SEL_ALARM && !permit) |=> $stable(alarmQ));

  // R5: init state never jumps straight to valid
  a_r5_no_skip: assert property (@(posedge slowClk) disable iff (!rstN)
    (stateQ == LP_INIT) |=> (stateQ != LP_VALID));

  // R5: the init-exit status follows a registered request
  a_r5_exit_after_req: assert property (@(posedge slowClk) disable iff (!rstN)
    $rose(statQ[S_INITDONE]) |-> $past(ctrlQ[C_INITEXIT]));

  // R11: losing the key leaves the valid state and drops status bit 14
  a_r11_key_lost: assert property (@(posedge slowClk) disable iff (!rstN)
    (stateQ == LP_VALID && !keyOk) |=> (stateQ == LP_NONVALID && !statQ[S_NVDONE]));

  // R9: alarm flag rises only from a match in the valid state
  a_r9_alarm_cause: assert property (@(posedge slowClk) disable iff (!rstN)
    $rose(statQ[S_ALARM]) |-> ($past(secsQ) == $past(alarmQ) && $past(stateQ) == LP_VALID));
endmodule

// File: rtl/rtc_lowpower.sv
module rtc_lowpower
  import rtc_lp_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              alarmIrq,
  output logic              wakeup
);
  wrReq_t    req;
  coreView_t view;

  rtc_bus_ctrl #(.ADDR_W(ADDR_W)) i_bus (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .view(view), .req(req), .rdData(rdData)
  );

  rtc_lp_core #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_core (
    .slowClk(slowClk), .rstN(rstN), .req(req), .view(view),
    .alarmIrq(alarmIrq), .wakeup(wakeup)
  );
endmodule

// File: tb/test_rtc_lowpower.sv
module test_rtc_lowpower;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_RATIO = 7;
  localparam int DIV        = 4;
  localparam logic [31:0] KEY = 32'h4173_6166;

  logic        clk = 1'b0, slowClk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic        alarmIrq, wakeup;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  rtc_lowpower #(.ADDR_W(5), .TICKS_PER_SEC(DIV)) i_rtc_lowpower (
    .clk(clk), .slowClk(slowClk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .alarmIrq(alarmIrq), .wakeup(wakeup)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin
    #32;
    forever begin slowClk = ~slowClk; #(CLK_PERIOD*SLOW_RATIO/2); end
  end

  // {offset, write data, expected readback}
  localparam logic [95:0] VEC [9] = '{
    {32'h18, 32'h1234_5678, 32'h1234_5678},
    {32'h18, 32'h0000_0000, 32'h0000_0000},
    {32'h08, 32'hAAAA_5555, 32'h0000_0000},
    {32'h04, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h10, 32'hFFFF_FFFF, 32'h0000_C898},
    {32'h08, 32'hAAAA_5555, 32'hAAAA_5555},
    {32'h00, 32'h0000_0100, 32'h0000_0100},
    {32'h10, 32'h0000_0000, 32'h0000_0000},
    {32'h00, 32'h0000_0200, 32'h0000_0100}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitSlow(input int n);
    repeat (n*SLOW_RATIO) @(negedge clk);
  endtask

  task automatic wrSync(input logic [4:0] a, input logic [31:0] d);
    busWrite(a, d); waitSlow(5);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b, s;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(5'h00, v); chk("R1 seconds", v, 0);
    rd(5'h04, v); chk("R1 sub", v, 0);
    rd(5'h08, v); chk("R1 alarm", v, 0);
    rd(5'h10, v); chk("R1 control", v, 0);
    rd(5'h14, v); chk("R1 status", v, 0);
    rd(5'h18, v); chk("R1 key", v, 0);
    chk("R1 irq", {31'd0, alarmIrq}, 0);
    chk("R1 wakeup", {31'd0, wakeup}, 0);

    // R2/R3 register table
    for (int i = 0; i < 9; i++) begin
      wrSync(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      chk($sformatf("R2 R3 table entry %0d", i), v, VEC[i][31:0]);
    end
    rd(5'h0C, v); chk("R2 unmapped", v, 0);
    rd(5'h14, v); chk("R5 no exit without key", v, 0);

    // bring-up
    wrSync(5'h18, KEY);
    wrSync(5'h14, 32'hFFFF_FFFF);
    busWrite(5'h10, 32'h0000_8800);
    repeat (6) @(negedge clk);
    rd(5'h14, v); chk("R5 exit not early", v, 0);
    waitSlow(5);
    rd(5'h14, v); chk("R5 init exited", v, 32'h0000_8000);
    wrSync(5'h10, 32'h0000_C808);
    rd(5'h14, v); chk("R6 nonvalid exited", v, 32'h0000_C000);

    // R7 counting
    wrSync(5'h00, 32'd5);
    rd(5'h04, a); waitSlow(1); rd(5'h04, b);
    chk("R7 sub step", b, (a + 1) % DIV);
    rd(5'h00, a); waitSlow(2*DIV); rd(5'h00, b);
    chk("R7 seconds advance", b, a + 2);

    // R4 latency and alarm
    rd(5'h00, s);
    busWrite(5'h08, s + 3);
    repeat (3*SLOW_RATIO) @(negedge clk);
    rd(5'h08, v); chk("R4 applied in three ticks", v, s + 3);
    rd(5'h14, v); chk("R9 no early alarm", v, 32'h0000_C000);
    waitSlow(4*DIV);
    rd(5'h14, v); chk("R9 alarm flag", v, 32'h0000_C008);
    chk("R10 irq masked", {31'd0, alarmIrq}, 0);
    chk("R10 wakeup masked", {31'd0, wakeup}, 0);
    wrSync(5'h10, 32'h0000_C898);
    chk("R10 irq on", {31'd0, alarmIrq}, 1);
    chk("R10 wakeup on", {31'd0, wakeup}, 1);
    wrSync(5'h10, 32'h0000_C818);
    chk("R10 irq off wake on irq", {31'd0, alarmIrq}, 0);
    chk("R10 wake on", {31'd0, wakeup}, 1);
    wrSync(5'h14, 32'h0000_0008);
    rd(5'h14, v); chk("R9 flag cleared", v, 32'h0000_C000);
    chk("R10 wakeup after clear", {31'd0, wakeup}, 0);

    // R7 low-power enable off freezes
    wrSync(5'h10, 32'h0000_C800);
    rd(5'h00, a); waitSlow(2*DIV); rd(5'h00, b);
    chk("R7 frozen without enable", b, a);
    wrSync(5'h10, 32'h0000_C808);

    // R8 saturation
    wrSync(5'h00, 32'hFFFF_FFFE);
    waitSlow(3*DIV);
    rd(5'h00, v); chk("R8 saturate", v, 32'hFFFF_FFFF);

    // R11 key lost
    wrSync(5'h00, 32'd40);
    wrSync(5'h18, 32'h0);
    rd(5'h14, v); chk("R11 status drop", v, 32'h0000_8000);
    rd(5'h00, a); waitSlow(2*DIV); rd(5'h00, b);
    chk("R11 counting stopped", b, a);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule